// File: doc/BRIEF.md
# Ambient Light Sensor Polling Controller

This block sequences register traffic toward an external ambient light sensor over a simple request/acknowledge register port. A serial bus engine sits behind that port. After reset the controller reads the sensor's identity register and checks it. It then writes a control word that selects automatic range, the stored conversion-time code and continuous operation. From then on it reads the two result registers in a loop and hands each pair of 16-bit words to a downstream decoder, marked by a one-cycle valid strobe.

Software-free runtime control comes through two pulse inputs. One pulse changes the conversion-time code, which makes the controller rewrite the control word between polls. The other requests power-down, which writes the control word with the operating mode cleared and then parks the controller. An error reported by the register port also parks the controller, in a fault state. A restart pulse leaves either parked state and repeats the boot sequence. The stored conversion-time code survives a restart.

Top module: `lux_poll_ctrl`

## Requirements
- R1: The first access after reset or restart is a read of address 0x11. When bits 11:0 of the returned word differ from 0x121, `id_warn_o` rises and stays high until the next restart, and the sequence continues regardless. Bits 15:12 are ignored.
- R2: Writes only ever target address 0x0A. The word written at boot sets bits 13:10 to 12 (automatic range), bits 9:6 to the stored time code and bits 5:4 to 3 (continuous), with every other bit zero. The code after reset is 11, so the boot word is 0x32F0.
- R3: In the poll loop the controller reads address 0x00 and then address 0x01, back to back. One cycle after the 0x01 acknowledge, `res_valid_o` pulses for one cycle, with `res_hi_o` and `res_lo_o` holding the two words read.
- R4: While `bus_req_o` is high and neither acknowledge nor error has arrived, the address, write flag and write data stay unchanged.
- R5: A conversion-time request with a code from 0 to 11 is stored. The next control write, issued after the current poll pair, carries the new code with automatic range and continuous mode.
- R6: A conversion-time request with a code above 11 produces a one-cycle `ctime_err_o` pulse in the cycle after the request. It causes no control write and leaves the stored code unchanged.
- R7: A power-down request writes address 0x0A with bits 5:4 cleared and the range and time fields unchanged. After that write, `bus_req_o` stays low until restart.
- R8: An error on the register port raises `fault_o` and holds `bus_req_o` low. A restart pulse clears the fault and repeats the boot sequence starting with the identity read.
- R9: When a power-down request and a conversion-time update are both pending, the power-down write is issued and the pending update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Pulse: leave the fault or off state and reboot |
| ctime_req_i | input | 1 | Pulse: request a conversion-time change |
| ctime_code_i | input | 4 | Requested conversion-time code |
| pdown_req_i | input | 1 | Pulse: request power-down |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 8 | Register address |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Access completed |
| bus_err_i | input | 1 | Access failed |
| res_valid_o | output | 1 | One-cycle strobe for a fresh result pair |
| res_hi_o | output | 16 | Upper result word (address 0x00) |
| res_lo_o | output | 16 | Lower result word (address 0x01) |
| id_warn_o | output | 1 | Identity mismatch seen at last boot |
| ctime_err_o | output | 1 | Pulse: out-of-range time code rejected |
| fault_o | output | 1 | Controller parked after a port error |

## Verification
The assertions assume the register port behaves as a single-outstanding responder. It raises acknowledge or error only while a request is pending, for one cycle, and never both at once. The bench responder follows this rule: it answers each request exactly once after a programmable latency, and then drops its response for at least one cycle. Conversion-time and power-down pulses are issued only right after a result strobe, when a read pair is in flight and no control write is pending. The write that follows a request therefore always reflects that request.

// File: rtl/lux_poll_pkg.sv
package lux_poll_pkg;
   typedef enum logic [2:0] {
      ST_ID   = 3'd0,
      ST_CFG  = 3'd1,
      ST_HI   = 3'd2,
      ST_LO   = 3'd3,
      ST_PDN  = 3'd4,
      ST_OFF  = 3'd5,
      ST_FLT  = 3'd6
   } lux_state_e;
endpackage

// File: rtl/lux_ctime_store.sv
module lux_ctime_store #(
   parameter int CODE_W   = 4,
   parameter int MAX_CODE = 11,
   parameter int DEF_CODE = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W-1:0] code_o,
   output logic              upd_o,
   output logic              err_o
);
   localparam int CODE_SPAN = 1 << CODE_W;

   if (MAX_CODE >= CODE_SPAN || DEF_CODE > MAX_CODE) begin : g_bad_cfg
      $error("lux_ctime_store: code limits do not fit CODE_W");
   end

   logic in_range;

   if (MAX_CODE < CODE_SPAN - 1) begin : g_chk
      assign in_range = (code_i <= CODE_W'(MAX_CODE));
   end else begin : g_nochk
      assign in_range = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= CODE_W'(DEF_CODE);
         upd_o  <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         upd_o <= req_i & in_range;
         err_o <= req_i & ~in_range;
         if (req_i && in_range) code_o <= code_i;
      end
   end

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      code_o <= CODE_W'(MAX_CODE)); // R6
   AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $stable(code_o)); // R6
endmodule

// File: rtl/lux_cword_pack.sv
module lux_cword_pack #(
   parameter int DATA_W     = 16,
   parameter int CODE_W     = 4,
   parameter int MODE_W     = 2,
   parameter int RANGE_LSB  = 10,
   parameter int TIME_LSB   = 6,
   parameter int MODE_LSB   = 4,
   parameter int RANGE_CODE = 12,
   parameter int MODE_CODE  = 3
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [DATA_W-1:0] word_o
);
   localparam int RANGE_W = 4;

   if (MODE_LSB + MODE_W > TIME_LSB || TIME_LSB + CODE_W > RANGE_LSB ||
       RANGE_LSB + RANGE_W > DATA_W) begin : g_bad_layout
      $error("lux_cword_pack: control fields overlap or overflow");
   end

   always_comb begin
      word_o = '0;
      word_o[RANGE_LSB +: RANGE_W] = RANGE_W'(RANGE_CODE);
      word_o[TIME_LSB  +: CODE_W]  = code_i;
      word_o[MODE_LSB  +: MODE_W]  = MODE_W'(MODE_CODE);
   end
endmodule

// File: rtl/lux_seq_fsm.sv
module lux_seq_fsm
   import lux_poll_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 16,
   parameter int          ID_BITS   = 12,
   parameter logic [11:0] ID_VALUE  = 12'h121,
   parameter logic [7:0]  ADR_HI    = 8'h00,
   parameter logic [7:0]  ADR_LO    = 8'h01,
   parameter logic [7:0]  ADR_CTRL  = 8'h0A,
   parameter logic [7:0]  ADR_ID    = 8'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              upd_i,
   input  logic              pdown_req_i,
   input  logic [DATA_W-1:0] cfg_word_i,
   input  logic [DATA_W-1:0] pdn_word_i,
   output logic              bus_req_o,
   output logic              bus_we_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic              bus_ack_i,
   input  logic              bus_err_i,
   output logic              res_valid_o,
   output logic [DATA_W-1:0] res_hi_o,
   output logic [DATA_W-1:0] res_lo_o,
   output logic              id_warn_o,
   output logic              fault_o
);
   if (ID_BITS > DATA_W || ID_BITS > 12 || ADDR_W < 8) begin : g_bad_cfg
      $error("lux_seq_fsm: identity or address width out of range");
   end

   lux_state_e state_q;
   logic       cfg_pend_q, pdn_pend_q;
   logic [DATA_W-1:0] wdata_q;
   logic       parked;
   lux_state_e disp_st;

   assign parked  = (state_q == ST_OFF) || (state_q == ST_FLT);
   assign disp_st = pdn_pend_q ? ST_PDN : (cfg_pend_q ? ST_CFG : ST_HI);

   always_comb begin
      bus_req_o  = !parked;
      bus_we_o   = (state_q == ST_CFG) || (state_q == ST_PDN);
      unique case (state_q)
         ST_ID:          bus_addr_o = ADDR_W'(ADR_ID);
         ST_HI:          bus_addr_o = ADDR_W'(ADR_HI);
         ST_LO:          bus_addr_o = ADDR_W'(ADR_LO);
         default:        bus_addr_o = ADDR_W'(ADR_CTRL);
      endcase
   end
   assign bus_wdata_o = wdata_q;
   assign fault_o     = (state_q == ST_FLT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_ID;
         cfg_pend_q  <= 1'b0;
         pdn_pend_q  <= 1'b0;
         wdata_q     <= '0;
         res_valid_o <= 1'b0;
         res_hi_o    <= '0;
         res_lo_o    <= '0;
         id_warn_o   <= 1'b0;
      end else begin
         res_valid_o <= 1'b0;
         if (upd_i) cfg_pend_q <= 1'b1;
         if (pdown_req_i && !parked) pdn_pend_q <= 1'b1;
         if (!parked && bus_err_i) begin
            state_q <= ST_FLT;
         end else if (!parked && bus_ack_i) begin
            case (state_q)
               ST_ID: begin
                  id_warn_o  <= (bus_rdata_i[ID_BITS-1:0] != ID_VALUE[ID_BITS-1:0]);
                  state_q    <= ST_CFG;
                  wdata_q    <= cfg_word_i;
                  cfg_pend_q <= upd_i;
               end
               ST_HI: begin
                  res_hi_o <= bus_rdata_i;
                  state_q  <= ST_LO;
               end
               ST_PDN: begin
                  state_q    <= ST_OFF;
                  pdn_pend_q <= 1'b0;
                  cfg_pend_q <= 1'b0;
               end
               default: begin
                  if (state_q == ST_LO) begin
                     res_lo_o    <= bus_rdata_i;
                     res_valid_o <= 1'b1;
                  end
                  state_q <= disp_st;
                  if (disp_st == ST_PDN) begin
                     wdata_q    <= pdn_word_i;
                     pdn_pend_q <= 1'b0;
                     cfg_pend_q <= 1'b0;
                  end else if (disp_st == ST_CFG) begin
                     wdata_q    <= cfg_word_i;
                     cfg_pend_q <= upd_i;
                  end
               end
            endcase
         end else if (parked && restart_i) begin
            state_q    <= ST_ID;
            id_warn_o  <= 1'b0;
            cfg_pend_q <= 1'b0;
            pdn_pend_q <= 1'b0;
         end
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_ack_i && !bus_err_i) |=>
      (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o))); // R4
   AST_WRITE_CTRL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_we_o) |-> (bus_addr_o == ADDR_W'(ADR_CTRL))); // R2
   AST_VALID_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> $past(bus_req_o && bus_ack_i && bus_addr_o == ADDR_W'(ADR_LO))); // R3
   AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> !bus_req_o); // R8
   AST_ERR_TO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_err_i) |=> fault_o); // R8
   AST_OFF_AFTER_PDN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_ack_i && bus_we_o && bus_wdata_o[5:4] == 2'b00) |=> !bus_req_o); // R7
endmodule

// File: rtl/lux_poll_ctrl.sv
module lux_poll_ctrl #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 16,
   parameter int CODE_W   = 4,
   parameter int MAX_CODE = 11,
   parameter int DEF_CODE = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              ctime_req_i,
   input  logic [CODE_W-1:0] ctime_code_i,
   input  logic              pdown_req_i,
   output logic              bus_req_o,
   output logic              bus_we_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic              bus_ack_i,
   input  logic              bus_err_i,
   output logic              res_valid_o,
   output logic [DATA_W-1:0] res_hi_o,
   output logic [DATA_W-1:0] res_lo_o,
   output logic              id_warn_o,
   output logic              ctime_err_o,
   output logic              fault_o
);
   localparam int MODE_CONT = 3;
   localparam int MODE_OFF  = 0;
   localparam int AUTO_RNG  = 12;

   logic [CODE_W-1:0] code_q;
   logic              upd;
   logic [DATA_W-1:0] cfg_word, pdn_word;

   lux_ctime_store #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .DEF_CODE(DEF_CODE)) u_store (
      .clk(clk), .rst_n(rst_n), .req_i(ctime_req_i), .code_i(ctime_code_i),
      .code_o(code_q), .upd_o(upd), .err_o(ctime_err_o));

   lux_cword_pack #(.DATA_W(DATA_W), .CODE_W(CODE_W), .RANGE_CODE(AUTO_RNG),
                    .MODE_CODE(MODE_CONT)) u_cfg_pack (
      .code_i(code_q), .word_o(cfg_word));

   lux_cword_pack #(.DATA_W(DATA_W), .CODE_W(CODE_W), .RANGE_CODE(AUTO_RNG),
                    .MODE_CODE(MODE_OFF)) u_pdn_pack (
      .code_i(code_q), .word_o(pdn_word));

   lux_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .upd_i(upd),
      .pdown_req_i(pdown_req_i), .cfg_word_i(cfg_word), .pdn_word_i(pdn_word),
      .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
      .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i),
      .bus_err_i(bus_err_i), .res_valid_o(res_valid_o), .res_hi_o(res_hi_o),
      .res_lo_o(res_lo_o), .id_warn_o(id_warn_o), .fault_o(fault_o));
endmodule

// File: tb/sim_lux_poll_ctrl.sv
module sim_lux_poll_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int WD_LIMIT   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic restart = 1'b0, treq = 1'b0, preq = 1'b0;
   logic [3:0] tcode = '0;
   logic breq, bwe, ack = 1'b0, err = 1'b0;
   logic [7:0] baddr;
   logic [15:0] bwdata, rdata = '0;
   logic rvalid, idwarn, terr, fault;
   logic [15:0] rhi, rlo;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int lat = 1, wcnt = 0, serve = 0, wr_cnt = 0, n_log = 0, n_valid = 0;
   int inj_req = 0, inj_done = 0;
   logic [15:0] id_val = 16'hF121, last_wdata = '0, last_waddr = '0;
   logic [15:0] exp_hi = '0, exp_lo = '0;
   logic [7:0] log_addr [0:511];

   always #(CLK_PERIOD/2) clk = ~clk;

   lux_poll_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .restart_i(restart), .ctime_req_i(treq),
      .ctime_code_i(tcode), .pdown_req_i(preq), .bus_req_o(breq), .bus_we_o(bwe),
      .bus_addr_o(baddr), .bus_wdata_o(bwdata), .bus_rdata_i(rdata), .bus_ack_i(ack),
      .bus_err_i(err), .res_valid_o(rvalid), .res_hi_o(rhi), .res_lo_o(rlo),
      .id_warn_o(idwarn), .ctime_err_o(terr), .fault_o(fault));

   function automatic logic [15:0] pat_hi(int s);
      return 16'(s * 16'h1F3D) ^ 16'hC0DE;
   endfunction
   function automatic logic [15:0] pat_lo(int s);
      return ~16'(s * 16'h0AB1);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // register-port responder: one response per request, after lat idle cycles
   always @(negedge clk) begin
      if (!rst_n) begin
         ack = 1'b0; err = 1'b0; wcnt = 0;
      end else if (ack || err) begin
         ack = 1'b0; err = 1'b0;
      end else if (breq) begin
         if (wcnt >= lat) begin
            wcnt = 0;
            if (inj_req != inj_done) begin
               err = 1'b1; inj_done++;
            end else begin
               ack = 1'b1;
               if (n_log < 512) log_addr[n_log] = baddr;
               n_log++;
               if (bwe) begin
                  wr_cnt++; last_wdata = bwdata; last_waddr = 16'(baddr);
               end else if (baddr == 8'h11) rdata = id_val;
               else if (baddr == 8'h00) begin serve++; rdata = pat_hi(serve); exp_hi = rdata; end
               else if (baddr == 8'h01) begin rdata = pat_lo(serve); exp_lo = rdata; end
               else rdata = 16'h0;
            end
         end else wcnt++;
      end
   end

   // result monitor
   always @(negedge clk) begin
      if (rst_n && rvalid) begin
         n_valid++;
         chk(rhi == exp_hi && rlo == exp_lo, "R3 result pair", {rhi, rlo}, {exp_hi, exp_lo});
         if (n_log >= 2 && n_log <= 512)
            chk(log_addr[n_log-2] == 8'h00 && log_addr[n_log-1] == 8'h01, "R3 read order",
                {log_addr[n_log-2], log_addr[n_log-1]}, 32'h0001);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc >= WD_LIMIT) begin
         n_fail++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   task automatic wait_valid();
      int v0 = n_valid;
      while (n_valid == v0) @(negedge clk);
   endtask

   task automatic wait_write();
      int w0 = wr_cnt;
      while (wr_cnt == w0) @(negedge clk);
   endtask

   initial begin
      int mark;
      repeat (3) @(negedge clk);
      chk(!fault && !rvalid && !idwarn && !terr, "reset state", {fault, rvalid, idwarn, terr}, 0);
      rst_n = 1'b1;
      wait_write();
      chk(log_addr[0] == 8'h11, "R1 first access is identity read", log_addr[0], 8'h11);
      chk(idwarn == 1'b0, "R1 matching identity, upper bits ignored", idwarn, 0);
      chk(last_waddr == 16'h0A && last_wdata == 16'h32F0, "R2 boot control word",
          {last_waddr, last_wdata}, {16'h0A, 16'h32F0});
      repeat (3) wait_valid();

      // R5 / R6 exhaustive sweep of every code value
      for (int c = 0; c < 16; c++) begin
         lat = c % 4;
         wait_valid();
         treq = 1'b1; tcode = 4'(c);
         @(negedge clk);
         treq = 1'b0;
         chk(terr == (c > 11), "R6 reject pulse", terr, (c > 11));
         if (c <= 11) begin
            wait_write();
            chk(last_waddr == 16'h0A && last_wdata == (16'h3030 | 16'(c << 6)),
                "R5 updated control word", last_wdata, 16'h3030 | 16'(c << 6));
         end else begin
            mark = wr_cnt;
            @(negedge clk);
            chk(terr == 1'b0, "R6 reject is one cycle", terr, 0);
            repeat (40) @(negedge clk);
            chk(wr_cnt == mark, "R6 no write after rejected code", wr_cnt, mark);
         end
      end

      // R9 power-down and update both pending, then R7 power-down word
      lat = 2;
      wait_valid();
      treq = 1'b1; tcode = 4'd5; preq = 1'b1;
      @(negedge clk);
      treq = 1'b0; preq = 1'b0;
      mark = wr_cnt;
      wait_write();
      chk(last_wdata == 16'h3140, "R9 power-down wins over pending update", last_wdata, 16'h3140);
      chk(wr_cnt == mark + 1, "R9 single write", wr_cnt, mark + 1);
      begin
         int hi_seen = 0;
         repeat (50) begin @(negedge clk); if (breq) hi_seen++; end
         chk(hi_seen == 0, "R7 port quiet after power-down", hi_seen, 0);
      end

      // R6 stored code kept: set 11 invalid path checked via power-down word after reboot
      id_val = 16'h0122;
      mark = n_log;
      restart = 1'b1; @(negedge clk); restart = 1'b0;
      wait_write();
      chk(log_addr[mark] == 8'h11, "R1 restart re-reads identity", log_addr[mark], 8'h11);
      chk(idwarn == 1'b1, "R1 identity mismatch warns", idwarn, 1);
      chk(last_wdata == 16'h3170, "R2 reboot word keeps stored code", last_wdata, 16'h3170);
      repeat (2) wait_valid();
      chk(idwarn == 1'b1, "R1 polling continues after mismatch", idwarn, 1);

      // R8 port error
      id_val = 16'h0121;
      inj_req++;
      while (!fault) @(negedge clk);
      begin
         int hi_seen = 0;
         repeat (20) begin @(negedge clk); if (breq || !fault) hi_seen++; end
         chk(hi_seen == 0, "R8 fault holds port idle", hi_seen, 0);
      end
      mark = n_log;
      restart = 1'b1; @(negedge clk); restart = 1'b0;
      @(negedge clk);
      chk(fault == 1'b0, "R8 restart clears fault", fault, 0);
      wait_write();
      chk(log_addr[mark] == 8'h11 && idwarn == 1'b0, "R8 reboot from identity read",
          {log_addr[mark], 7'b0, idwarn}, 16'h1100);
      wait_valid();

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule